// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Events

This block controls 32 general-purpose pins and is reached over a simple 32-bit register bus. Every pin has three control bits: one selects whether it drives, one selects open-drain drive, and one holds its output value. The pad side gets a per-pin output value and a per-pin output enable. Incoming pad levels are synchronised, and the bus can read them back.

Edges on the synchronised inputs are caught in a per-pin event latch. A per-pin sense bit chooses between catching falling edges only and catching both edges. Software clears an event by writing a one to its bit. A per-pin enable decides which latched events reach the single interrupt line. Read-modify-write of the data word is safe, because output pins read back the value software stored rather than the pad level.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Pin n maps to register bit 31−n, so pin 0 is the MSB. The register offsets are: drive-enable 0x00, open-drain 0x04, data 0x08, event 0x0C, interrupt enable 0x10 and edge sense 0x14. The drive-enable, open-drain, interrupt-enable and edge-sense registers read back exactly what was last written.
- R2: After reset every register reads zero, `pad_oe` and `pad_out` are zero and `irq` is low.
- R3: A pin whose drive-enable bit is 1 and whose open-drain bit is 0 has `pad_oe` high and `pad_out` equal to its data bit. A pin whose drive-enable bit is 0 never has `pad_oe` high.
- R4: For an input pin, a data-register read returns the pad level two clock edges after that level is applied. For an output pin, it returns the last written data bit, whatever the pad level is.
- R5: `irq` is high exactly when some bit is set in both the event register and the interrupt-enable register. An all-zero enable keeps `irq` low.
- R6: An edge-sense bit of 1 latches only falling edges of the pin. A bit of 0 latches both rising and falling edges. The event bit reads 1 after the third rising clock edge that follows the pad change.
- R7: A pin with its drive-enable and open-drain bits both 1 never drives `pad_out` high. Its `pad_oe` is high only while its data bit is 0.
- R8: Writing the event register clears each bit written as 1. Bits written as 0 keep their value, and a write never sets an event bit.
- R9: If a new edge and a clearing write reach the same event bit in the same clock, the bit stays set.
- R10: Reads of any offset other than the six listed in R1 return zero. Writes to such offsets change no register.
- R11: Edges are latched whether or not the pin's interrupt enable is set. Setting the enable later raises `irq` for an event that is already latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe; zero otherwise |
| pad_in | input | 32 | Pad input levels, index = pin number |
| pad_out | output | 32 | Pad output values, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: 32 pins and an 8-bit offset. With these, the full bit reversal between pad index and register bit can be seen, and so can every mapped and unmapped offset. Under this build the bench checks the three-edge latency from a pad change to a latched event. It also lines up a clearing write with the exact cycle in which a new edge is captured, which exercises the priority rule in R9.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Register byte offsets
  localparam logic [31:0] OFS_DRIVE = 32'h00;
  localparam logic [31:0] OFS_OPEN  = 32'h04;
  localparam logic [31:0] OFS_DATA  = 32'h08;
  localparam logic [31:0] OFS_EVENT = 32'h0C;
  localparam logic [31:0] OFS_IEN   = 32'h10;
  localparam logic [31:0] OFS_SENSE = 32'h14;

  typedef enum logic [2:0] {
    SEL_DRIVE,
    SEL_OPEN,
    SEL_DATA,
    SEL_EVENT,
    SEL_IEN,
    SEL_SENSE,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
    reg_sel_e r;
    case (ofs)
      OFS_DRIVE: r = SEL_DRIVE;
      OFS_OPEN:  r = SEL_OPEN;
      OFS_DATA:  r = SEL_DATA;
      OFS_EVENT: r = SEL_EVENT;
      OFS_IEN:   r = SEL_IEN;
      OFS_SENSE: r = SEL_SENSE;
      default:   r = SEL_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Reorders pads into register-bit order, synchronises them and flags edges.
module gpio_in_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  logic [NPINS-1:0] pad_bits;
  logic [NPINS-1:0] meta_q, sync_q, prev_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_map
    localparam int B = NPINS - 1 - p;
    assign pad_bits[B] = pad_in[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_bits;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_evt_latch.sv
// Per-bit event latch: edge capture by sense select, clear by writing ones.
module gpio_evt_latch #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  input  logic [NPINS-1:0] fall_only,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] capture,
  output logic [NPINS-1:0] evt_q
);
  function automatic logic [NPINS-1:0] pick_edges(
    input logic [NPINS-1:0] r, input logic [NPINS-1:0] f,
    input logic [NPINS-1:0] fo);
    return f | (r & ~fo);
  endfunction

  function automatic logic [NPINS-1:0] next_events(
    input logic [NPINS-1:0] cur, input logic [NPINS-1:0] clr,
    input logic [NPINS-1:0] cap);
    // capture is ORed last so a same-cycle edge beats the clear
    return (cur & ~clr) | cap;
  endfunction

  logic [NPINS-1:0] clr_eff;

  assign capture = pick_edges(rise, fall, fall_only);
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= next_events(evt_q, clr_eff, capture);
  end
endmodule

// File: rtl/gpio_pad_drive.sv
// Converts register-bit-order controls into pin-order pad drive.
module gpio_pad_drive #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] drive,
  input  logic [NPINS-1:0] open_drain,
  input  logic [NPINS-1:0] data,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int B = NPINS - 1 - p;
    // open drain: enable only to pull low, never drive a one
    assign pad_oe[p]  = drive[B] & (~open_drain[B] | ~data[B]);
    assign pad_out[p] = drive[B] & ~open_drain[B] & data[B];
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  localparam int DW = NPINS;

  logic [DW-1:0] drive_q, open_q, data_q, ien_q, sense_q;
  logic [DW-1:0] level, rise, fall, capture, evt_q, rd_mux;
  reg_sel_e      sel;
  logic          wr_en, rd_en, unmapped, evt_clr_we;

  function automatic logic [DW-1:0] data_view(
    input logic [DW-1:0] lvl, input logic [DW-1:0] drv,
    input logic [DW-1:0] stored);
    return (lvl & ~drv) | (stored & drv);
  endfunction

  assign sel        = decode_offset(32'(bus_addr));
  assign wr_en      = bus_sel & bus_wr;
  assign rd_en      = bus_sel & ~bus_wr;
  assign unmapped   = (sel == SEL_NONE);
  assign evt_clr_we = wr_en & (sel == SEL_EVENT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      open_q  <= '0;
      data_q  <= '0;
      ien_q   <= '0;
      sense_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DRIVE: drive_q <= bus_wdata;
        SEL_OPEN:  open_q  <= bus_wdata;
        SEL_DATA:  data_q  <= bus_wdata;
        SEL_IEN:   ien_q   <= bus_wdata;
        SEL_SENSE: sense_q <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DRIVE: rd_mux = drive_q;
      SEL_OPEN:  rd_mux = open_q;
      SEL_DATA:  rd_mux = data_view(level, drive_q, data_q);
      SEL_EVENT: rd_mux = evt_q;
      SEL_IEN:   rd_mux = ien_q;
      SEL_SENSE: rd_mux = sense_q;
      default:   rd_mux = '0;
    endcase
  end

  assign bus_rdata = rd_en ? rd_mux : '0;

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pad_in(pad_in),
    .level (level),
    .rise  (rise),
    .fall  (fall)
  );

  gpio_evt_latch #(.NPINS(NPINS)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .fall     (fall),
    .fall_only(sense_q),
    .clr_we   (evt_clr_we),
    .clr_mask (bus_wdata),
    .capture  (capture),
    .evt_q    (evt_q)
  );

  gpio_pad_drive #(.NPINS(NPINS)) u_pad (
    .drive     (drive_q),
    .open_drain(open_q),
    .data      (data_q),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  assign irq = |(evt_q & ien_q);
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] drive_q,
  input logic [NPINS-1:0] open_q,
  input logic [NPINS-1:0] ien_q,
  input logic [NPINS-1:0] evt_q,
  input logic [NPINS-1:0] capture,
  input logic             evt_clr_we,
  input logic             rd_en,
  input logic             unmapped,
  input logic [NPINS-1:0] bus_rdata
);
  logic [NPINS-1:0] drive_pin, open_pin;

  for (genvar p = 0; p < NPINS; p++) begin : g_rev
    assign drive_pin[p] = drive_q[NPINS-1-p];
    assign open_pin[p]  = open_q[NPINS-1-p];
  end

  a_r5_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  a_r3_input_never_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~drive_pin) == '0);

  a_r7_open_drain_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & open_pin) == '0);

  a_r8_events_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_clr_we |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (capture != '0) |=> ((evt_q & $past(capture)) == $past(capture)));

  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |-> (bus_rdata == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .drive_q   (drive_q),
  .open_q    (open_q),
  .ien_q     (ien_q),
  .evt_q     (evt_q),
  .capture   (capture),
  .evt_clr_we(evt_clr_we),
  .rd_en     (rd_en),
  .unmapped  (unmapped),
  .bus_rdata (bus_rdata)
);

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_ctrl uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .irq      (irq)
  );

  // pin n lives in register bit 31-n
  function automatic logic [31:0] pb(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_pad(input int n, input logic v);
    @(negedge clk);
    pad_in[n] = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(8'(a * 4), d);
      chk("R2 reset register", d, 32'h0);
    end
    chk("R2 reset oe", pad_oe, 32'h0);
    chk("R2 reset out", pad_out, 32'h0);
    chk("R2 reset irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h04, 32'hA5A5_0F0F); rd(8'h04, d); chk("R1 open-drain readback", d, 32'hA5A5_0F0F);
    wr(8'h10, 32'h1234_5678); rd(8'h10, d); chk("R1 enable readback", d, 32'h1234_5678);
    wr(8'h14, 32'hC3C3_3C3C); rd(8'h14, d); chk("R1 sense readback", d, 32'hC3C3_3C3C);
    wr(8'h00, pb(0));         rd(8'h00, d); chk("R1 pin0 is MSB", d, 32'h8000_0000);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h10, 32'h0); wr(8'h14, 32'h0);
  endtask

  task automatic t_push_pull();
    wr(8'h08, pb(10));
    wr(8'h00, pb(10));
    #1;
    chk("R3 push-pull oe", pad_oe, 32'h1 << 10);
    chk("R3 push-pull high", pad_out, 32'h1 << 10);
    wr(8'h08, 32'h0);
    #1;
    chk("R3 push-pull low", pad_out, 32'h0);
    chk("R3 push-pull oe kept", pad_oe, 32'h1 << 10);
    wr(8'h00, 32'h0);
    #1;
    chk("R3 input no oe", pad_oe, 32'h0);
  endtask

  task automatic t_open_drain();
    wr(8'h04, pb(11));
    wr(8'h08, pb(11));
    wr(8'h00, pb(11));
    #1;
    chk("R7 released when one", pad_oe, 32'h0);
    chk("R7 never high", pad_out, 32'h0);
    wr(8'h08, 32'h0);
    #1;
    chk("R7 pulls low oe", pad_oe, 32'h1 << 11);
    chk("R7 pulls low out", pad_out, 32'h0);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    // pin 8 output storing 1 while pad reads 0; pin 7 input at 1
    wr(8'h08, pb(8));
    wr(8'h00, pb(8));
    @(negedge clk);
    pad_in[7] = 1'b1;
    @(posedge clk); @(posedge clk);
    #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h08;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
    chk("R4 input level and output stored value", d, pb(7) | pb(8));
    set_pad(7, 1'b0);
    settle();
    rd(8'h08, d);
    chk("R4 input follows pad", d, pb(8));
    wr(8'h00, 32'h0); wr(8'h08, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(8'h14, pb(2));         // pin 2 falling only, pin 3 both
    set_pad(2, 1'b1); settle();
    rd(8'h0C, d); chk("R6 rising ignored on falling-only pin", d, 32'h0);
    set_pad(2, 1'b0); settle();
    rd(8'h0C, d); chk("R6 falling latched", d, pb(2));
    set_pad(3, 1'b1);
    repeat (2) @(posedge clk);
    #1 bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h0C;
    #1 d = bus_rdata; bus_sel = 1'b0;
    chk("R6 not yet after two edges", d, pb(2));
    @(posedge clk);
    rd(8'h0C, d); chk("R6 rising latched on both-edge pin", d, pb(2) | pb(3));
    chk("R11 masked event no irq", {31'h0, irq}, 32'h0);
    wr(8'h10, pb(3));
    #1 chk("R11 R5 enable raises irq", {31'h0, irq}, 32'h1);
    wr(8'h10, pb(5));
    #1 chk("R5 other enable no irq", {31'h0, irq}, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    set_pad(3, 1'b0); settle();
    rd(8'h0C, d); chk("R6 falling on both-edge pin", d, pb(3));
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h10, 32'h0); wr(8'h14, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    set_pad(4, 1'b1); set_pad(6, 1'b1); settle();
    wr(8'h0C, 32'h0);
    rd(8'h0C, d); chk("R8 zeros keep events", d, pb(4) | pb(6));
    wr(8'h0C, pb(4));
    rd(8'h0C, d); chk("R8 single bit clear", d, pb(6));
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R8 all clear", d, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    // pin 5 and pin 4 events set; then clear both while pin 5 gets a new edge
    set_pad(5, 1'b1); set_pad(4, 1'b0); settle();
    rd(8'h0C, d); chk("R9 setup events", d, pb(4) | pb(5));
    @(negedge clk);
    pad_in[5] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = pb(4) | pb(5);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h0C, d); chk("R9 new edge beats clear", d, pb(5));
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h18, d); chk("R10 unmapped read zero", d, 32'h0);
    rd(8'h02, d); chk("R10 misaligned read zero", d, 32'h0);
    for (int a = 0; a < 6; a++) begin
      if (a == 2) continue;
      rd(8'(a * 4), d);
      chk("R10 unmapped write no effect", d, 32'h0);
    end
    chk("R10 pads untouched", pad_oe, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_push_pull();
    t_open_drain();
    t_readback();
    t_edges();
    t_clear();
    t_collision();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule